// File: doc/BRIEF.md
# Zero-Squeezing Entry Compactor

This block accepts a vector of eight byte-wide entries on a load strobe and, on that same clock edge, stores a copy in which every nonzero entry has moved toward slot 0. The nonzero entries keep the order they had on the input, and the slots left over are filled with zeros. The result is complete one edge after the input is presented, and no intermediate shifting passes are needed. For example, the input sequence 0,4,0,0,5,0,2,0, listed from entry 0 upward, becomes 4,5,2,0,0,0,0,0.

Each output slot has its own selector. First, a running count of the nonzero inputs is formed across the input vector. Slot k then takes the single input that is nonzero and whose running count equals k+1. Because that input can only sit at index k or higher, the mux for slot 0 has eight sources and the mux for the last slot has only one. A flag marks the cycle in which a fresh result is present. Between loads the outputs keep their value.

Top module: `zc_compactor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output slot reads zero and `valid_o` is low.
- R2: Input entry i is carried on `data_i[i*8 +: 8]` and output slot k is carried on `slot_o[k*8 +: 8]`. After a load, slot k holds the (k+1)-th nonzero input, counted from entry 0 upward, so the relative order of the nonzero inputs is kept.
- R3: Each slot draws from at most one input per load, and slot k draws only from inputs k through 7. A single nonzero entry at index 7 therefore lands in slot 0.
- R4: If fewer than k+1 inputs are nonzero, slot k is zero. Once a slot is zero, every higher slot is zero as well.
- R5: The last slot is nonzero only when all eight inputs are nonzero.
- R6: The compacted result appears on the clock edge that samples `load_i` high. `valid_o` is high for exactly the cycle after each load and low in every other cycle.
- R7: With `load_i` low, `data_i` has no effect, and `slot_o` keeps its previous value.
- R8: An all-zero input yields all-zero slots. An input with no zero entries is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Sample `data_i` and store its compacted form |
| data_i | input | 64 | Eight input entries, entry i at bits i*8+7:i*8 |
| slot_o | output | 64 | Eight registered output slots, slot k at bits k*8+7:k*8 |
| valid_o | output | 1 | High in the cycle after a load |

## Verification
The assertions place no restriction on the content of `data_i`. Any mix of zero and nonzero entries is legal, and every property must hold for each of them. The properties do assume that `load_i` and `data_i` are stable at the rising edge. The bench meets this by changing them only on falling edges. The random loads draw each entry as zero with even odds, which covers both sparse and dense inputs, and idle cycles with changing data are mixed in to exercise the hold behaviour.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int ZC_ENTRIES = 8;
  localparam int ZC_WIDTH   = 8;

  // width of a running count that can reach n
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/zc_nz_prefix.sv
module zc_nz_prefix #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0][W-1:0]  ent,
  output logic [N-1:0]         nz,
  output logic [N-1:0][CW-1:0] run_cnt
);
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      nz[i]      = |ent[i];
      acc        = acc + CW'(nz[i]);
      run_cnt[i] = acc;
    end
  end
endmodule

// File: rtl/zc_slot_mux.sv
module zc_slot_mux #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int CW = 4,
  parameter int K  = 0
) (
  input  logic [N-1:0][W-1:0]  ent,
  input  logic [N-1:0]         nz,
  input  logic [N-1:0][CW-1:0] run_cnt,
  output logic [N-1:0]         pick,
  output logic [W-1:0]         val
);
  localparam logic [CW-1:0] RANK = CW'(K + 1);

  always_comb begin
    pick = '0;
    val  = '0;
    for (int i = K; i < N; i++) begin
      pick[i] = nz[i] && (run_cnt[i] == RANK);
      if (pick[i]) val = val | ent[i];
    end
  end
endmodule

// File: rtl/zc_compactor.sv
module zc_compactor
  import zc_pkg::*;
#(
  parameter int N = ZC_ENTRIES,
  parameter int W = ZC_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [N*W-1:0] data_i,
  output logic [N*W-1:0] slot_o,
  output logic         valid_o
);
  localparam int CW = cnt_bits(N);

  logic [N-1:0][W-1:0]  ent_in;
  logic [N-1:0]         in_nz;
  logic [N-1:0][CW-1:0] in_run;
  logic [N-1:0][W-1:0]  next_slot;
  logic [N-1:0][N-1:0]  slot_pick;
  logic [N-1:0][W-1:0]  slot_q;
  logic [N-1:0]         out_nz;
  logic [CW-1:0]        in_total;

  assign ent_in   = data_i;
  assign in_total = in_run[N-1];

  zc_nz_prefix #(.N(N), .W(W), .CW(CW)) u_prefix (
    .ent     (ent_in),
    .nz      (in_nz),
    .run_cnt (in_run)
  );

  for (genvar k = 0; k < N; k++) begin : g_slot
    zc_slot_mux #(.N(N), .W(W), .CW(CW), .K(k)) u_mux (
      .ent     (ent_in),
      .nz      (in_nz),
      .run_cnt (in_run),
      .pick    (slot_pick[k]),
      .val     (next_slot[k])
    );
    assign out_nz[k] = |slot_q[k];

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(slot_pick[k])); // R3

    if (k > 0) begin : g_tail
      AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (rst)
        !out_nz[k-1] |-> !out_nz[k]); // R4
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) slot_q <= next_slot;
    end
  end

  assign slot_o = slot_q;

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> valid_o); // R6
  AST_VALID_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> !valid_o); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(slot_q)); // R7
  AST_COUNT_KEPT: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (CW'($countones(out_nz)) == $past(in_total))); // R2
  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    (load_i && !(&in_nz)) |=> !out_nz[N-1]); // R5
endmodule

// File: tb/zc_compactor_tb.sv
module zc_compactor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [N*W-1:0] din = '0;
  wire  [N*W-1:0] slots;
  wire            valid;

  int checks = 0;
  int errors = 0;
  logic [N*W-1:0] exp_q = '0;
  logic           exp_v = 1'b0;

  zc_compactor u_dut (
    .clk(clk), .rst(rst), .load_i(load), .data_i(din),
    .slot_o(slots), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] d);
    logic [W-1:0] kept[$];
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++)
      if (d[i*W +: W] != '0) kept.push_back(d[i*W +: W]);
    r = '0;
    for (int k = 0; k < kept.size(); k++) r[k*W +: W] = kept[k];
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (slots !== exp_q || valid !== exp_v) begin
      errors++;
      $display("FAIL %s: slots=%h valid=%b expected slots=%h valid=%b",
               tag, slots, valid, exp_q, exp_v);
    end
  endtask

  task automatic cycle(input logic ld, input logic [N*W-1:0] d, input string tag);
    @(negedge clk);
    load = ld;
    din  = d;
    @(posedge clk);
    #1;
    if (ld) exp_q = model(d);
    exp_v = ld;
    check(tag);
  endtask

  function automatic logic [N*W-1:0] pack8(input logic [W-1:0] e0, e1, e2, e3,
                                           e4, e5, e6, e7);
    return {e7, e6, e5, e4, e3, e2, e1, e0};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset");

    // example from the requirement: 0,4,0,0,5,0,2,0 -> 4,5,2,0,...
    cycle(1'b1, pack8(8'd0, 8'd4, 8'd0, 8'd0, 8'd5, 8'd0, 8'd2, 8'd0), "R2 example");
    if (slots[23:0] !== 24'h020504) begin
      checks++; errors++;
      $display("FAIL R2 low slots: actual %h expected 020504", slots[23:0]);
    end else checks++;
    cycle(1'b0, {N{8'hAA}}, "R7 idle hold");
    cycle(1'b0, '0, "R6 valid low idle");
    cycle(1'b1, pack8(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'h9C), "R3 entry7 to slot0");
    cycle(1'b1, pack8(8'd1, 8'd0, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0), "R4 sparse tail zero");
    cycle(1'b1, '0, "R8 all zero");
    cycle(1'b1, pack8(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8), "R8 all nonzero identity");
    cycle(1'b1, pack8(8'd9, 8'd8, 8'd7, 8'd0, 8'd5, 8'd4, 8'd3, 8'd2), "R5 one zero last slot");
    cycle(1'b1, pack8(8'hFF, 8'h01, 8'h80, 8'h7F, 8'h10, 8'h20, 8'h40, 8'h11), "R5 all nonzero last slot");
    cycle(1'b1, pack8(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0), "R6 back-to-back load");

    for (int n = 0; n < 500; n++) begin
      logic [N*W-1:0] d;
      logic ld;
      for (int i = 0; i < N; i++)
        d[i*W +: W] = ($urandom % 2 == 0) ? 8'd0 : 8'(($urandom % 255) + 1);
      ld = ($urandom % 4) != 0;
      cycle(ld, d, ld ? "R2 random load" : "R7 random idle");
    end

    @(negedge clk);
    rst = 1'b1;
    load = 1'b0;
    @(posedge clk);
    #1;
    exp_q = '0;
    exp_v = 1'b0;
    check("R1 re-reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule